// File: doc/BRIEF.md
# DSP Status Word and Exception Acceptance

This block keeps the 16-bit status word of a small fixed-point signal processor that has a 40-bit accumulator. The word is updated from four sources. An arithmetic flag update derives condition bits from an accumulator result. A logic-zero update comes from mask-test operations. A single-bit set or clear instruction names a bit by a 3-bit index. A full-word load comes from a register move. A full-word load in a cycle overrides every other source. Otherwise the flag update, the logic-zero update and the single-bit operation combine, and the single-bit operation wins on the bit it names.

The block also collects exception requests, one line per exception number. It keeps as pending only those requests that the enable bits allow to be kept. It picks the lowest-numbered pending request that is currently enabled and presents it as an acknowledge. The external interrupt has two enables. Either enable lets it through, and one of the two clears itself each time any exception is taken. All pins are plain control and status signals. Requests are single-cycle strobes, and the acknowledge is a single-cycle indication that the surrounding sequencer takes without a handshake.

Top module: `dsp_status_ctl`

## Requirements
- R1: A synchronous active-high `rst` clears the status word, all pending requests and the acknowledge outputs to 0.
- R2: Bit 8 of `sr_q` always reads 0. A full-word load (`wr_en`) stores `wr_data` into every other bit on the next clock edge.
- R3: A flag update (`flag_upd`) writes the low six bits from the accumulator result and the ALU strobes. Bit 0 takes `carry_in` and bit 1 takes `ovf_in`. Bit 2 is set when the result is all zero, and bit 3 takes result bit 39. Bit 4 is set when result bits 39..31 are not all equal, that is, when the value does not fit in 32 signed bits. Bit 5 is set when result bits 31 and 30 are equal. Bit 6 and bits 8..15 do not change.
- R4: Bit 7 (sticky overflow) is set by a flag update with `ovf_in` = 1. A flag update with `ovf_in` = 0 clears bit 1 but leaves bit 7 unchanged.
- R5: `lz_upd` loads bit 6 (logic zero) from `lz_val`. A flag update never changes bit 6.
- R6: When `bit_en` is high, `bit_val` is written into the bit that `bit_idx` names. Index 0 names bit 6, index 1 names bit 7, index 3 names bit 9, index 5 names bit 11 and index 6 names bit 12. Indices 2, 4 and 7 have no effect.
- R7: In a cycle with `wr_en` high, `flag_upd`, `lz_upd` and `bit_en` are ignored. Without `wr_en`, a single-bit operation overrides a flag update on the same bit.
- R8: A request on any line other than the external one (`EXT_IDX`, default 7) is kept pending only if bit 9 is 1 in the cycle it arrives. Otherwise it is discarded for good. A pending request of this kind is taken only while bit 9 is 1.
- R9: An external request is always kept pending, whatever the enables. It is taken only while bit 11 or bit 12 is 1.
- R10: Among the pending requests that may be taken, the lowest number wins. `ack_vld`, the one-hot `ack_oh` and the binary `ack_idx` report the winner for one cycle, and only that request is cleared at the following edge.
- R11: When any exception is taken, bit 12 is 0 after the next edge. This holds even if a load or a bit operation writes it in that cycle. Bit 11 is not changed by taking an exception.
- R12: A request that is kept pending at an edge is visible on the acknowledge outputs in the cycle after that edge, provided it may be taken and no lower-numbered request is eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Full-word load strobe |
| wr_data | input | 16 | Word to load |
| flag_upd | input | 1 | Arithmetic flag update strobe |
| acc_res | input | 40 | Accumulator result for the flag update |
| carry_in | input | 1 | Carry produced by the ALU |
| ovf_in | input | 1 | Overflow produced by the ALU |
| lz_upd | input | 1 | Logic-zero update strobe |
| lz_val | input | 1 | Logic-zero value |
| bit_en | input | 1 | Single-bit operation strobe |
| bit_val | input | 1 | Value for the single-bit operation (1 set, 0 clear) |
| bit_idx | input | 3 | Index of the bit to set or clear |
| exc_req | input | 8 | Exception request strobes, one per exception number |
| sr_q | output | 16 | Status word |
| ack_vld | output | 1 | An exception is taken this cycle |
| ack_oh | output | 8 | One-hot number of the taken exception |
| ack_idx | output | 3 | Binary number of the taken exception |

## Verification
A wrong bit in the status word shows up on `sr_q` one edge after the operation that wrote it. A fault in the pending set stays hidden until the enables allow the request through. For that reason the bench probes each request twice: once while it is disabled, and again after the enable is raised, so that a request that was wrongly kept reappears as an acknowledge one cycle later. A fault in the selection order or in the clearing of a taken request shows on `ack_idx` over two consecutive cycles, when two requests are raised together.

// File: rtl/dsp_sr_pkg.sv
package dsp_sr_pkg;
  localparam int SR_W      = 16;
  localparam int B_CARRY   = 0;
  localparam int B_OVF     = 1;
  localparam int B_AZERO   = 2;
  localparam int B_SIGN    = 3;
  localparam int B_OVER32  = 4;
  localparam int B_TOP2    = 5;
  localparam int B_LZERO   = 6;
  localparam int B_STICKY  = 7;
  localparam int B_RSV8    = 8;
  localparam int B_IE      = 9;
  localparam int B_XIE_A   = 11;
  localparam int B_XIE_B   = 12;
  localparam int FLAG_BITS = 6;

  typedef struct packed {
    logic       hit;
    logic [3:0] pos;
  } bitsel_t;

  // Index to status bit position for single-bit operations.
  function automatic bitsel_t map_bit_idx(input logic [2:0] idx);
    bitsel_t s;
    s.hit = 1'b1;
    case (idx)
      3'd0:    s.pos = 4'(B_LZERO);
      3'd1:    s.pos = 4'(B_STICKY);
      3'd3:    s.pos = 4'(B_IE);
      3'd5:    s.pos = 4'(B_XIE_A);
      3'd6:    s.pos = 4'(B_XIE_B);
      default: begin s.hit = 1'b0; s.pos = 4'd0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sr_flag_eval.sv
module sr_flag_eval #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic [ACC_W-1:0]         acc,
  input  logic                     carry_in,
  input  logic                     ovf_in,
  output logic [dsp_sr_pkg::FLAG_BITS-1:0] flags
);
  import dsp_sr_pkg::*;
  localparam int LOW_W = ACC_W - GUARD_W;

  logic [GUARD_W:0] ext_bits;
  logic             all_one, all_zero;

  assign ext_bits = acc[ACC_W-1:LOW_W-1];
  assign all_one  = &ext_bits;
  assign all_zero = ~|ext_bits;

  always_comb begin
    flags           = '0;
    flags[B_CARRY]  = carry_in;
    flags[B_OVF]    = ovf_in;
    flags[B_AZERO]  = (acc == '0);
    flags[B_SIGN]   = acc[ACC_W-1];
    flags[B_OVER32] = ~(all_one | all_zero);
    flags[B_TOP2]   = (acc[LOW_W-1] == acc[LOW_W-2]);
  end
endmodule

// File: rtl/sr_exc_arb.sv
module sr_exc_arb #(
  parameter int N_EXC   = 8,
  parameter int EXT_IDX = 7,
  localparam int IDXW   = $clog2(N_EXC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXC-1:0] req,
  input  logic             ie,
  input  logic             xie,
  output logic             ack_vld,
  output logic [N_EXC-1:0] ack_oh,
  output logic [IDXW-1:0]  ack_idx
);
  localparam logic [N_EXC-1:0] EXT_MASK    = N_EXC'(1) << EXT_IDX;
  localparam logic [N_EXC-1:0] NONEXT_MASK = ~EXT_MASK;

  logic [N_EXC-1:0] pend_q, keep, elig;

  // Non-external requests are discarded while disabled; external always kept.
  assign keep = req & (ie ? '1 : EXT_MASK);
  assign elig = pend_q & (ie ? '1 : EXT_MASK) & (xie ? '1 : NONEXT_MASK);

  always_comb begin
    ack_oh  = '0;
    ack_idx = '0;
    for (int i = N_EXC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        ack_oh    = '0;
        ack_oh[i] = 1'b1;
        ack_idx   = IDXW'(i);
      end
    end
  end
  assign ack_vld = |elig;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~ack_oh) | keep;
  end

  // R10: at most one acknowledge
  a_r10_onehot_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_oh));
  // R10: only the taken request leaves, unless re-raised
  a_r10_taken_cleared: assert property (@(posedge clk) disable iff (rst)
    ack_vld |=> ((pend_q & $past(ack_oh & ~req)) == '0));
  // R8: nothing non-external becomes pending while disabled
  a_r8_drop_disabled: assert property (@(posedge clk) disable iff (rst)
    !ie |=> ((pend_q & ~$past(pend_q) & NONEXT_MASK) == '0));
  // R8: non-external taken only with general enable
  a_r8_ie_gate: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && !ack_oh[EXT_IDX]) |-> ie);
  // R9: external taken only with one of its enables
  a_r9_ext_gate: assert property (@(posedge clk) disable iff (rst)
    ack_oh[EXT_IDX] |-> xie);
endmodule

// File: rtl/dsp_status_ctl.sv
module dsp_status_ctl #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8,
  parameter int N_EXC   = 8,
  parameter int EXT_IDX = 7,
  localparam int IDXW   = $clog2(N_EXC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             flag_upd,
  input  logic [ACC_W-1:0] acc_res,
  input  logic             carry_in,
  input  logic             ovf_in,
  input  logic             lz_upd,
  input  logic             lz_val,
  input  logic             bit_en,
  input  logic             bit_val,
  input  logic [2:0]       bit_idx,
  input  logic [N_EXC-1:0] exc_req,
  output logic [15:0]      sr_q,
  output logic             ack_vld,
  output logic [N_EXC-1:0] ack_oh,
  output logic [IDXW-1:0]  ack_idx
);
  import dsp_sr_pkg::*;

  logic [FLAG_BITS-1:0] flags;
  logic [SR_W-1:0]      sr_d;
  bitsel_t              bsel;

  sr_flag_eval #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_flags (
    .acc(acc_res), .carry_in(carry_in), .ovf_in(ovf_in), .flags(flags));

  sr_exc_arb #(.N_EXC(N_EXC), .EXT_IDX(EXT_IDX)) u_arb (
    .clk(clk), .rst(rst), .req(exc_req),
    .ie(sr_q[B_IE]), .xie(sr_q[B_XIE_A] | sr_q[B_XIE_B]),
    .ack_vld(ack_vld), .ack_oh(ack_oh), .ack_idx(ack_idx));

  assign bsel = map_bit_idx(bit_idx);

  always_comb begin
    sr_d = sr_q;
    if (wr_en) begin
      sr_d = wr_data;
    end else begin
      if (flag_upd) begin
        sr_d[FLAG_BITS-1:0] = flags;
        if (ovf_in) sr_d[B_STICKY] = 1'b1;
      end
      if (lz_upd) sr_d[B_LZERO] = lz_val;
      if (bit_en && bsel.hit) sr_d[bsel.pos] = bit_val;
    end
    if (ack_vld) sr_d[B_XIE_B] = 1'b0;
    sr_d[B_RSV8] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end

  // R2: reserved bit reads zero
  a_r2_bit8_zero: assert property (@(posedge clk) disable iff (rst)
    sr_q[B_RSV8] == 1'b0);
  // R4: overflow in a flag update leaves sticky set
  a_r4_sticky_set: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && ovf_in && !wr_en && !(bit_en && bit_idx == 3'd1 && !bit_val))
    |=> sr_q[B_STICKY]);
  // R3 / R5: a lone flag update keeps bits above the flag field, except sticky
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && !wr_en && !lz_upd && !bit_en && !ack_vld)
    |=> ({sr_q[15:8], sr_q[B_LZERO]} == $past({sr_q[15:8], sr_q[B_LZERO]})));
  // R11: enable B is low after any exception is taken
  a_r11_xie_b_cleared: assert property (@(posedge clk) disable iff (rst)
    ack_vld |=> !sr_q[B_XIE_B]);
  // R11: enable A untouched by exception entry
  a_r11_xie_a_kept: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && !wr_en && !bit_en) |=> (sr_q[B_XIE_A] == $past(sr_q[B_XIE_A])));
endmodule

// File: tb/tb_dsp_status_ctl.sv
module tb_dsp_status_ctl;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, flag_upd, carry_in, ovf_in, lz_upd, lz_val, bit_en, bit_val;
  logic [15:0] wr_data;
  logic [39:0] acc_res;
  logic [2:0]  bit_idx;
  logic [7:0]  exc_req;
  logic [15:0] sr_q;
  logic        ack_vld;
  logic [7:0]  ack_oh;
  logic [2:0]  ack_idx;

  always #4 clk = ~clk;

  dsp_status_ctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .flag_upd(flag_upd),
    .acc_res(acc_res), .carry_in(carry_in), .ovf_in(ovf_in), .lz_upd(lz_upd),
    .lz_val(lz_val), .bit_en(bit_en), .bit_val(bit_val), .bit_idx(bit_idx),
    .exc_req(exc_req), .sr_q(sr_q), .ack_vld(ack_vld), .ack_oh(ack_oh),
    .ack_idx(ack_idx));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] q_sr[$];
  logic        q_vld[$];
  logic [2:0]  q_idx[$];
  string       q_tag[$];

  logic [15:0] m_sr;
  logic [7:0]  m_pend;

  function automatic logic [7:0] m_elig(input logic [15:0] s, input logic [7:0] p);
    logic [7:0] e;
    e = p;
    if (!s[9]) e = e & 8'h80;
    if (!(s[11] | s[12])) e = e & 8'h7F;
    return e;
  endfunction

  function automatic int m_pos(input logic [2:0] i);
    case (i)
      3'd0: return 6;
      3'd1: return 7;
      3'd3: return 9;
      3'd5: return 11;
      3'd6: return 12;
      default: return -1;
    endcase
  endfunction

  task automatic idle_inputs();
    rst = 0; wr_en = 0; wr_data = '0; flag_upd = 0; acc_res = '0; carry_in = 0;
    ovf_in = 0; lz_upd = 0; lz_val = 0; bit_en = 0; bit_val = 0; bit_idx = '0;
    exc_req = '0;
  endtask

  // Driver: advance the reference model, run one edge, push the expectation.
  task automatic cyc(input string tag);
    logic [7:0]  e, take;
    logic [15:0] n;
    int p;
    e = m_elig(m_sr, m_pend);
    take = '0;
    for (int i = 7; i >= 0; i--) if (e[i]) begin take = '0; take[i] = 1'b1; end
    if (rst) begin
      m_sr = '0; m_pend = '0;
    end else begin
      n = m_sr;
      if (wr_en) n = wr_data;
      else begin
        if (flag_upd) begin
          n[0] = carry_in;
          n[1] = ovf_in;
          n[2] = (acc_res == 40'd0);
          n[3] = acc_res[39];
          n[4] = !((acc_res[39:31] == 9'h1FF) || (acc_res[39:31] == 9'h000));
          n[5] = (acc_res[31] == acc_res[30]);
          if (ovf_in) n[7] = 1'b1;
        end
        if (lz_upd) n[6] = lz_val;
        p = m_pos(bit_idx);
        if (bit_en && p >= 0) n[p] = bit_val;
      end
      if (take != 0) n[12] = 1'b0;
      n[8] = 1'b0;
      m_pend = (m_pend & ~take) | (exc_req & (m_sr[9] ? 8'hFF : 8'h80));
      m_sr = n;
    end
    @(posedge clk);
    #1;
    e = m_elig(m_sr, m_pend);
    take = '0;
    for (int i = 7; i >= 0; i--) if (e[i]) begin take = '0; take[i] = 1'b1; end
    q_sr.push_back(m_sr);
    q_vld.push_back(take != 0);
    q_idx.push_back(3'($clog2(int'(take) + 1) - 1));
    q_tag.push_back(tag);
    @(negedge clk);
    idle_inputs();
  endtask

  // Monitor: pop and compare away from the active edge.
  always @(negedge clk) begin
    while (q_sr.size() > 0) begin
      logic [15:0] xs; logic xv; logic [2:0] xi; string t;
      xs = q_sr.pop_front(); xv = q_vld.pop_front(); xi = q_idx.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (sr_q !== xs || ack_vld !== xv || (xv && (ack_idx !== xi || ack_oh !== (8'h1 << xi)))) begin
        fails++;
        $display("FAIL %s: sr=%h vld=%b idx=%0d oh=%b, expected sr=%h vld=%b idx=%0d",
                 t, sr_q, ack_vld, ack_idx, ack_oh, xs, xv, xi);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    m_sr = '0; m_pend = '0;
    @(negedge clk);
    rst = 1; cyc("R1 reset");
    rst = 1; cyc("R1 reset hold");
    wr_en = 1; wr_data = 16'hFFFF; cyc("R2 load all ones, bit8 reads 0");
    wr_en = 1; wr_data = 16'h0000; cyc("R2 load zero");
    flag_upd = 1; acc_res = 40'h0; carry_in = 1; cyc("R3 zero result with carry");
    flag_upd = 1; acc_res = 40'h80_0000_0000; cyc("R3 negative, over 32 bits");
    flag_upd = 1; acc_res = 40'h00_4000_0001; cyc("R3 top two bits differ");
    flag_upd = 1; acc_res = 40'hFF_C000_0000; cyc("R3 fits 32 bits, negative");
    flag_upd = 1; acc_res = 40'h00_0000_0005; ovf_in = 1; cyc("R4 overflow sets sticky");
    flag_upd = 1; acc_res = 40'h00_0000_0005; ovf_in = 0; cyc("R4 sticky survives");
    lz_upd = 1; lz_val = 1; cyc("R5 logic zero load");
    flag_upd = 1; acc_res = 40'h12_3456_789A; cyc("R5 flag update keeps logic zero");
    bit_en = 1; bit_val = 1; bit_idx = 3'd2; cyc("R6 index 2 no effect");
    bit_en = 1; bit_val = 1; bit_idx = 3'd4; cyc("R6 index 4 no effect");
    bit_en = 1; bit_val = 1; bit_idx = 3'd7; cyc("R6 index 7 no effect");
    bit_en = 1; bit_val = 0; bit_idx = 3'd1; cyc("R6 clear sticky via index 1");
    bit_en = 1; bit_val = 0; bit_idx = 3'd0; flag_upd = 1; acc_res = 40'h0; cyc("R6 clear logic zero with flag update");
    wr_en = 1; wr_data = 16'h2000; flag_upd = 1; ovf_in = 1; lz_upd = 1; lz_val = 1;
    bit_en = 1; bit_val = 1; bit_idx = 3'd3; cyc("R7 load wins over other sources");
    exc_req = 8'h04; cyc("R8 request dropped while disabled");
    bit_en = 1; bit_val = 1; bit_idx = 3'd3; cyc("R8 enable raised, dropped request absent");
    exc_req = 8'h80; cyc("R9 external pending without enables");
    cyc("R9 external still waiting");
    bit_en = 1; bit_val = 1; bit_idx = 3'd6; cyc("R9 enable B lets external through, R12");
    cyc("R11 enable B cleared after entry");
    bit_en = 1; bit_val = 1; bit_idx = 3'd5; cyc("R11 set enable A");
    bit_en = 1; bit_val = 1; bit_idx = 3'd6; exc_req = 8'h24; cyc("R10 two requests, lowest first");
    cyc("R10 second request next");
    cyc("R11 enable A kept, B cleared");
    exc_req = 8'h80; cyc("R9 external through enable A");
    wr_en = 1; wr_data = 16'h1A00; cyc("R11 load during entry still clears B");
    bit_en = 1; bit_val = 0; bit_idx = 3'd3; exc_req = 8'h01; cyc("R8 request latched with enable set");
    cyc("R8 pending request waits for enable");
    bit_en = 1; bit_val = 1; bit_idx = 3'd3; cyc("R8 enable raised, pending request taken");
    cyc("R10 acknowledge lasts one cycle");
    rst = 1; cyc("R1 reset clears state");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule